// File: doc/BRIEF.md
# Pin Direction Finder

This block works out which pins of an unidentified digital device are outputs. A mask marks the supply and ground positions, and those pins are left alone. Every other pin is a signal pin. The block takes the signal pins one at a time as the candidate and assumes the candidate is an output. It then drives the other signal pins through every binary combination of levels and watches the candidate. If the candidate's level changes at any point, the candidate is an output. If the level stays fixed for the whole sweep, the candidate is an input.

A scan begins with a one-cycle start request. The block copies the exclusion mask and a settle length at that moment. For each new combination it drives the pattern, waits for the device to settle, and then samples the candidate. The first sample for a candidate becomes that candidate's reference level. Once a candidate shows a difference, the block skips the rest of that candidate's combinations. When every pin has been visited, the block raises done for one cycle, and the result mask stays on its port until the next scan starts.

Top module: `pin_dir_finder`

## Requirements
- R1: After synchronous reset: busy, done, out_mask and drive_en are all 0.
- R2: A start request is accepted only while idle. Acceptance captures excl_mask and settle_len. A start request that arrives while busy is ignored, including in the cycle when done is high.
- R3: Pins set in the captured exclusion mask are never candidates, are never driven (their drive_en bit stays 0), and never appear in out_mask.
- R4: While a candidate is being tested, drive_en has a 1 on every non-excluded pin except the candidate, and a 0 on the candidate.
- R5: The driven pattern comes from a binary counter. Counter bit j goes to the j-th enabled pin, counted in ascending pin order. For each candidate the counter starts at 0 and counts up by 1. drive_val is 0 on every pin that is not enabled.
- R6: Every combination takes settle_len+3 cycles: one cycle to apply, settle_len+1 cycles to wait, and one cycle to sample. Visiting each pin position takes one cycle, and so does the final check. The done cycle is one more. Busy is therefore high for (pins+1) + Σ(combinations used)·(settle_len+3) + 1 cycles.
- R7: The level sampled on combination 0 is the reference. A candidate whose level equals the reference for all 2^m combinations (m = number of enabled pins) is an input, and its out_mask bit is 0.
- R8: As soon as a sampled level differs from the reference, the candidate's out_mask bit is set to 1 and the block moves to the next pin. The remaining combinations for that candidate are not applied.
- R9: done is a one-cycle pulse. busy is low in the next cycle. out_mask keeps the final result until the next accepted start.
- R10: A candidate with no other signal pins (m = 0) gets exactly one combination and is classified as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan request, sampled only when idle |
| excl_mask | input | NPINS | 1 marks a supply or ground pin to leave alone |
| settle_len | input | SETTLE_W | Extra wait cycles after each new pattern |
| pin_level | input | NPINS | Levels read back from the device pins |
| drive_val | output | NPINS | Levels driven onto enabled pins |
| drive_en | output | NPINS | 1 where the tester drives the pin |
| busy | output | 1 | High from acceptance of start through the done cycle |
| done | output | 1 | One-cycle pulse when all pins are classified |
| out_mask | output | NPINS | 1 for each pin classified as an output |

## Verification
There are two places where block functions coincide in a single cycle.

The first is a start request arriving while busy. The bench raises start in the same cycle as done, and also in the middle of a scan with an inverted exclusion mask. To pass, the result mask must not change, the busy length must match the arithmetic prediction, and busy must stay low after the done pulse.

The second is a level change on the final combination, where detection and sweep exhaustion land in the same sample cycle. This is provoked by a device model whose output only moves on the all-ones pattern. It must be classified as an output, and the cycle count must include every combination it used.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_APPLY,
        ST_WAIT,
        ST_SAMPLE,
        ST_DONE
    } pdf_state_e;

    typedef enum logic [1:0] {
        VD_HOLD,
        VD_NEXT,
        VD_OUTPUT,
        VD_INPUT
    } pdf_verdict_e;

    function automatic logic is_final(input pdf_verdict_e v);
        return (v == VD_OUTPUT) || (v == VD_INPUT);
    endfunction

endpackage

// File: rtl/pdf_pattern.sv
module pdf_pattern #(
    parameter int NPINS = 20
) (
    input  logic [NPINS-1:0] combo,
    input  logic [NPINS-1:0] en_mask,
    output logic [NPINS-1:0] pattern,
    output logic             last
);
    localparam int JW = $clog2(NPINS + 1);

    logic [JW-1:0]    j;
    logic [NPINS-1:0] lim;
    logic [NPINS-1:0] ones;
    int               m;

    always_comb begin
        j       = '0;
        pattern = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (en_mask[p]) begin
                pattern[p] = combo[j];
                j          = j + JW'(1);
            end
        end
    end

    always_comb begin
        ones = '1;
        m    = $countones(en_mask);
        lim  = ~(ones << m);
        last = (combo == lim);
    end

endmodule

// File: rtl/pdf_settle.sv
module pdf_settle #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SETTLE_W-1:0] len,
    output logic                expired
);
    logic [SETTLE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - SETTLE_W'(1);
        end
    end

    assign expired = (cnt == '0) && !load;

    a_r6_load_then_wait: assert property (@(posedge clk) disable iff (rst)
        load |=> !expired || ($past(len) == '0));

endmodule

// File: rtl/pdf_judge.sv
module pdf_judge
    import pdf_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         sample_en,
    input  logic         last,
    input  logic         level,
    output pdf_verdict_e verdict
);
    logic have_ref;
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_ref <= 1'b0;
            ref_q    <= 1'b0;
        end else if (sample_en && !have_ref) begin
            have_ref <= 1'b1;
            ref_q    <= level;
        end
    end

    always_comb begin
        if (!sample_en)                   verdict = VD_HOLD;
        else if (have_ref && level != ref_q) verdict = VD_OUTPUT;
        else if (last)                    verdict = VD_INPUT;
        else                              verdict = VD_NEXT;
    end

    a_r7_ref_kept: assert property (@(posedge clk) disable iff (rst)
        (have_ref && !clear) |=> ($stable(ref_q) && have_ref));

endmodule

// File: rtl/pin_dir_finder.sv
module pin_dir_finder
    import pdf_pkg::*;
#(
    parameter int NPINS    = 20,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NPINS-1:0]    excl_mask,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [NPINS-1:0]    pin_level,
    output logic [NPINS-1:0]    drive_val,
    output logic [NPINS-1:0]    drive_en,
    output logic                busy,
    output logic                done,
    output logic [NPINS-1:0]    out_mask
);
    localparam int CW = $clog2(NPINS + 1);

    pdf_state_e          st;
    logic [CW-1:0]       cand;
    logic [NPINS-1:0]    combo;
    logic [NPINS-1:0]    excl_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [NPINS-1:0]    cand_hot;
    logic [NPINS-1:0]    en_mask;
    logic [NPINS-1:0]    pattern;
    logic                last;
    logic                expired;
    logic                level;
    logic                cand_end;
    pdf_verdict_e        verdict;

    assign cand_end = (cand == CW'(NPINS));
    assign cand_hot = cand_end ? '0 : (NPINS'(1) << cand);
    assign en_mask  = ~excl_q & ~cand_hot;
    assign level    = cand_end ? 1'b0 : pin_level[cand];
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_DONE);

    pdf_pattern #(.NPINS(NPINS)) u_pattern (
        .combo   (combo),
        .en_mask (en_mask),
        .pattern (pattern),
        .last    (last)
    );

    pdf_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .load    (st == ST_APPLY),
        .len     (settle_q),
        .expired (expired)
    );

    pdf_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .clear     (st == ST_SELECT),
        .sample_en (st == ST_SAMPLE),
        .last      (last),
        .level     (level),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cand      <= '0;
            combo     <= '0;
            excl_q    <= '0;
            settle_q  <= '0;
            out_mask  <= '0;
            drive_val <= '0;
            drive_en  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        excl_q   <= excl_mask;
                        settle_q <= settle_len;
                        out_mask <= '0;
                        cand     <= '0;
                        st       <= ST_SELECT;
                    end
                end
                ST_SELECT: begin
                    if (cand_end) begin
                        drive_en  <= '0;
                        drive_val <= '0;
                        st        <= ST_DONE;
                    end else if (excl_q[cand]) begin
                        cand <= cand + CW'(1);
                    end else begin
                        combo <= '0;
                        st    <= ST_APPLY;
                    end
                end
                ST_APPLY: begin
                    drive_en  <= en_mask;
                    drive_val <= pattern;
                    st        <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (expired) st <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (is_final(verdict)) begin
                        if (verdict == VD_OUTPUT) out_mask[cand] <= 1'b1;
                        cand <= cand + CW'(1);
                        st   <= ST_SELECT;
                    end else begin
                        combo <= combo + NPINS'(1);
                        st    <= ST_APPLY;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r3_excl_undriven: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((drive_en & excl_q) == '0));

    a_r4_cand_undriven: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT || st == ST_SAMPLE) |-> ((drive_en & cand_hot) == '0));

    a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> (busy && $stable(excl_q)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r8_mask_grows: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ((out_mask & $past(out_mask)) == $past(out_mask)));

    a_r3_mask_excl: assert property (@(posedge clk) disable iff (rst)
        done |-> ((out_mask & excl_q) == '0));

    a_r6_stable_at_sample: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SAMPLE) |-> ($stable(drive_val) && $stable(drive_en)));

endmodule

// File: tb/pin_dir_finder_test.sv
module pin_dir_finder_test;
    localparam int NP = 6;
    localparam int SW = 4;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [NP-1:0] excl_in;
    logic [SW-1:0] settle_in;
    logic [NP-1:0] pin_lv;
    logic [NP-1:0] drive_val, drive_en, out_mask;
    logic          busy, done;

    int checks = 0;
    int errors = 0;

    // kind: 0 input pin, 1 AND of src, 2 XOR of src, 3 constant high
    int            kind [NP];
    logic [NP-1:0] src  [NP];
    logic [NP-1:0] cur_excl;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_dir_finder #(.NPINS(NP), .SETTLE_W(SW)) uut (
        .clk(clk), .rst(rst), .start(start), .excl_mask(excl_in),
        .settle_len(settle_in), .pin_level(pin_lv), .drive_val(drive_val),
        .drive_en(drive_en), .busy(busy), .done(done), .out_mask(out_mask)
    );

    function automatic logic [NP-1:0] model_vec(input logic [NP-1:0] dv, input logic [NP-1:0] de);
        logic [NP-1:0] tin, r;
        for (int q = 0; q < NP; q++) tin[q] = (kind[q] == 0) && de[q] && dv[q];
        for (int p = 0; p < NP; p++) begin
            case (kind[p])
                1:       r[p] = ((tin & src[p]) == src[p]);
                2:       r[p] = ^(tin & src[p]);
                3:       r[p] = 1'b1;
                default: r[p] = tin[p];
            endcase
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] spread(input int k, input logic [NP-1:0] en);
        logic [NP-1:0] r = '0;
        int b = 0;
        for (int p = 0; p < NP; p++) if (en[p]) begin r[p] = k[b]; b++; end
        return r;
    endfunction

    function automatic void predict(input logic [NP-1:0] ex, input int s,
                                    output logic [NP-1:0] om, output int cyc);
        om  = '0;
        cyc = NP + 2;
        for (int c = 0; c < NP; c++) begin
            logic [NP-1:0] en, v;
            logic rl;
            int n, used;
            if (ex[c]) continue;
            en   = ~ex & ~(NP'(1) << c);
            n    = 1 << $countones(en);
            v    = model_vec(spread(0, en), en);
            rl   = v[c];
            used = n;
            for (int k = 1; k < n; k++) begin
                v = model_vec(spread(k, en), en);
                if (v[c] != rl) begin used = k + 1; om[c] = 1'b1; break; end
            end
            cyc += used * (s + 3);
        end
    endfunction

    always_ff @(posedge clk) pin_lv <= model_vec(drive_val, drive_en);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pattern monitor (R4, R5)
    logic [NP-1:0] prev_en = '0, prev_val = '0;
    int            kcnt = 0;
    always @(negedge clk) begin
        if (busy && drive_en != '0 && (drive_en != prev_en || drive_val != prev_val)) begin
            if (drive_en != prev_en) kcnt = 0; else kcnt++;
            chk(drive_val == spread(kcnt, drive_en), "R5 pattern", int'(drive_val), int'(spread(kcnt, drive_en)));
            chk(((drive_en & cur_excl) == '0) &&
                ($countones(drive_en) == $countones(~cur_excl) - 1), "R4 enable set",
                int'(drive_en), int'(~cur_excl));
        end
        prev_en  = drive_en;
        prev_val = drive_val;
    end

    task automatic run(input logic [NP-1:0] ex, input int s, input bit poke, input string tag);
        logic [NP-1:0] om_e, om;
        int cyc_e, cyc, wd;
        bit seen;
        predict(ex, s, om_e, cyc_e);
        cur_excl  = ex;
        excl_in   = ex;
        settle_in = SW'(s);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; wd = 0; seen = 0; om = '0;
        while (busy && wd < 20000) begin
            cyc++;
            if (poke && cyc == 5) begin start = 1'b1; excl_in = ~ex; end
            else if (poke && cyc == 6) begin start = 1'b0; excl_in = ex; end
            if (done) begin
                om = out_mask; seen = 1;
                if (poke) start = 1'b1;
            end
            @(negedge clk);
            wd++;
        end
        start = 1'b0;
        chk(wd < 20000, {tag, " R9 finished"}, wd, 0);
        chk(seen, {tag, " R9 done pulse"}, int'(seen), 1);
        chk(om == om_e, {tag, " R7 R8 output mask"}, int'(om), int'(om_e));
        chk(cyc == cyc_e, {tag, " R6 busy cycles"}, cyc, cyc_e);
        @(negedge clk);
        chk(!busy && out_mask == om_e, {tag, " R9 R2 idle and held"}, int'(out_mask), int'(om_e));
        chk((out_mask & ex) == '0, {tag, " R3 excluded not in mask"}, int'(out_mask & ex), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; excl_in = '0; settle_in = '0; cur_excl = '0;
        for (int p = 0; p < NP; p++) begin kind[p] = 0; src[p] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && out_mask == '0 && drive_en == '0, "R1 reset state",
            int'(out_mask), 0);

        // A: two outputs (AND, XOR of pins 1,2), supply on 0 and 5
        kind[3] = 1; src[3] = 6'b000110;
        kind[4] = 2; src[4] = 6'b000110;
        run(6'b100001, 2, 1'b0, "A");

        // B: no exclusions, late-changing AND, stuck-high pin, XOR of one pin
        for (int p = 0; p < NP; p++) begin kind[p] = 0; src[p] = '0; end
        kind[2] = 1; src[2] = 6'b001011;
        kind[4] = 3;
        kind[5] = 2; src[5] = 6'b000001;
        run(6'b000000, 0, 1'b0, "B");

        // C: output changes only on the all-ones pattern (last combination)
        for (int p = 0; p < NP; p++) begin kind[p] = 0; src[p] = '0; end
        kind[1] = 1; src[1] = 6'b011100;
        run(6'b100001, 3, 1'b0, "C last-combo R8");

        // D: single signal pin, m = 0 (R10)
        for (int p = 0; p < NP; p++) begin kind[p] = 0; src[p] = '0; end
        run(6'b111110, 1, 1'b0, "D R10");

        // E: everything excluded
        run(6'b111111, 2, 1'b0, "E R3");

        // F: scenario A again with start pokes mid-run and on done (R2)
        kind[3] = 1; src[3] = 6'b000110;
        kind[4] = 2; src[4] = 6'b000110;
        run(6'b100001, 2, 1'b1, "F R2");
        @(negedge clk);
        chk(!busy, "R2 no restart after done-cycle start", int'(busy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule